// File: doc/BRIEF.md
# Coalescing Half-Line Write Buffer

This block sits between a data cache and the memory write path and holds outgoing stores until memory takes them. Storage is a ring of entries, each covering one 16-byte half of a 32-byte cache line. Each entry carries a per-byte valid mask. Two request streams feed it:

- Word stores with byte strobes. Each store says whether its target memory allows coalescing.
- Cache evictions. An eviction carries a line address, two per-half dirty bits and the full 32 bytes of the line.

Coalescing stores merge into a waiting entry for the same half line. Non-coalescing stores and dirty halves from evictions always take fresh entries.

Entries leave one at a time through a simple write port: address, data and mask are held with a valid flag until the memory acknowledges. They leave in the order they were allocated. When there is no room, the requester is held off with a ready signal. A lone entry starts draining only on a cycle when no request is waiting. This leaves room for a burst of stores to the same half line to merge before the entry starts its write.

Top module: `wbuf_coalesce`

## Requirements
- R1: After reset the buffer is empty: `mw_valid` is 0, and `st_ready` and `ev_ready` are 1 while no eviction is presented.
- R2: A store with `st_coal` = 0 always takes a fresh entry and becomes its own memory write. Such an entry is never a merge target. The write's mask has byte lane `4*st_addr[1:0]+k` set for each strobe bit k, and its address is `st_addr[29:2]`.
- R3: A store with `st_coal` = 1 merges into a waiting coalescable entry with the same half-line address (`st_addr[29:2]`). The entry's mask becomes the OR of both masks, and the newer bytes replace older bytes.
- R4: A coalescing store never merges into the entry whose write has been offered (`mw_valid` high for it). It takes a fresh entry instead.
- R5: An eviction of line L takes one entry per dirty half, with a full mask:
  - `ev_dirty[0]` covers half address 2L with `ev_data[127:0]`.
  - `ev_dirty[1]` covers half address 2L+1 with `ev_data[255:128]`.
  - When both halves are dirty, the lower half drains first.
- R6: An eviction with `ev_dirty` = 00 is accepted at once and produces no memory write.
- R7: An eviction needing two entries is accepted only when two entries are free, and then both are allocated in the same cycle. Occupancy never exceeds DEPTH.
- R8: A store is stalled (`st_ready` = 0) while an eviction is presented. It is also stalled when all entries are in use and the store has no merge target.
- R9: Entries drain in allocation order, one per cycle in which `mw_valid` and `mw_ack` are both high. While `mw_ack` is low, `mw_valid`, `mw_addr`, `mw_data` and `mw_mask` hold.
- R10: When exactly one entry is held and its write has not been offered, `mw_valid` stays 0 during any cycle in which a store or eviction is presented. `mw_valid` rises in the first cycle with no request presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store accepted this cycle |
| st_coal | input | 1 | Target memory allows coalescing |
| st_addr | input | 30 | Word address of the store |
| st_strb | input | 4 | Byte strobes of the word |
| st_data | input | 32 | Store data |
| ev_valid | input | 1 | Eviction request present |
| ev_ready | output | 1 | Eviction accepted this cycle |
| ev_line | input | 27 | Cache line address |
| ev_dirty | input | 2 | Dirty bit per half (bit 0 lower) |
| ev_data | input | 256 | Full line data |
| mw_valid | output | 1 | Memory write offered |
| mw_ack | input | 1 | Memory takes the write |
| mw_addr | output | 28 | Half-line address of the write |
| mw_data | output | 128 | Half-line data |
| mw_mask | output | 16 | Byte-valid mask |

## Verification
`st_ready` and `ev_ready` are combinational, so each is due in the same cycle its request is presented. The memory-port outputs are read from the head entry without a register stage, so an accepted request shows on the port in the cycle right after the accepting edge, unless the lone-entry wait of R10 applies. A popped entry is replaced by the next one in the cycle after the acknowledging edge. The bench drives every input on the falling edge and samples one nanosecond later, after the combinational paths have settled. For each drain it waits for `mw_valid` before comparing address, mask and the masked data bytes.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

   // Kind of request the allocator grants in a cycle.
   typedef enum logic [1:0] {
      WB_REQ_IDLE  = 2'd0,
      WB_REQ_STORE = 2'd1,
      WB_REQ_EVICT = 2'd2
   } wb_req_e;

   // Number of entries an eviction needs: one per dirty half.
   function automatic logic [1:0] dirty_count(input logic [1:0] d);
      return {1'b0, d[0]} + {1'b0, d[1]};
   endfunction

endpackage

// File: rtl/wbuf_match.sv
// Finds the entry a coalescing store may merge into.
module wbuf_match #(
   parameter int DEPTH  = 8,
   parameter int TAG_W  = 28,
   parameter bit ENABLE = 1'b1
) (
   input  logic [DEPTH-1:0]         cand,
   input  logic [TAG_W-1:0]         tags [DEPTH],
   input  logic [TAG_W-1:0]         probe,
   output logic                     hit,
   output logic [$clog2(DEPTH)-1:0] hit_idx
);
   localparam int IDX_W = $clog2(DEPTH);

   logic [DEPTH-1:0] eq;

   generate
      if (ENABLE) begin : g_cmp
         for (genvar i = 0; i < DEPTH; i++) begin : g_ent
            assign eq[i] = cand[i] && (tags[i] == probe);
         end
      end else begin : g_off
         assign eq = '0;
      end
   endgenerate

   // At most one candidate can match; the encoder takes the lowest slot.
   always_comb begin
      hit     = |eq;
      hit_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (eq[i]) hit_idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/wbuf_alloc.sv
// Decides which request is granted and how many entries it takes.
module wbuf_alloc
   import wbuf_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             st_valid,
   input  logic             st_coal,
   input  logic             hit,
   input  logic             ev_valid,
   input  logic [1:0]       ev_dirty,
   input  logic [CNT_W-1:0] free_cnt,
   output logic             st_ready,
   output logic             ev_ready,
   output logic             st_merge,
   output logic [1:0]       push_n,
   output wb_req_e          req_kind
);
   logic [1:0] ev_need;

   always_comb begin
      ev_need  = dirty_count(ev_dirty);
      // All-or-nothing: both halves of an eviction must fit at once.
      ev_ready = free_cnt >= CNT_W'(ev_need);
      st_merge = st_coal && hit;
      // Evictions take priority; a store waits while one is presented.
      st_ready = !ev_valid && (st_merge || (free_cnt != '0));
      if (ev_valid && ev_ready) begin
         req_kind = WB_REQ_EVICT;
         push_n   = ev_need;
      end else if (st_valid && st_ready) begin
         req_kind = WB_REQ_STORE;
         push_n   = st_merge ? 2'd0 : 2'd1;
      end else begin
         req_kind = WB_REQ_IDLE;
         push_n   = 2'd0;
      end
   end
endmodule

// File: rtl/wbuf_drain.sv
// Offers the head entry to memory and holds it until acknowledged.
module wbuf_drain (
   input  logic clk,
   input  logic rst_n,
   input  logic head_valid,
   input  logic multi,
   input  logic req_present,
   input  logic mw_ack,
   output logic mw_valid,
   output logic head_lock,
   output logic pop
);
   logic launched;
   logic launch_now;

   // A lone entry waits while requests arrive, so a burst can merge first.
   assign launch_now = head_valid && !launched && (multi || !req_present);
   assign mw_valid   = launched || launch_now;
   assign head_lock  = mw_valid;
   assign pop        = mw_valid && mw_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) launched <= 1'b0;
      else        launched <= mw_valid && !mw_ack;
   end
endmodule

// File: rtl/wbuf_coalesce.sv
module wbuf_coalesce
   import wbuf_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DEPTH       = 8,
   parameter int LINE_BYTES  = 32,
   parameter int WORD_BYTES  = 4,
   parameter bit COALESCE_EN = 1'b1
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic                                       st_valid,
   output logic                                       st_ready,
   input  logic                                       st_coal,
   input  logic [ADDR_W-$clog2(WORD_BYTES)-1:0]       st_addr,
   input  logic [WORD_BYTES-1:0]                      st_strb,
   input  logic [8*WORD_BYTES-1:0]                    st_data,
   input  logic                                       ev_valid,
   output logic                                       ev_ready,
   input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0]       ev_line,
   input  logic [1:0]                                 ev_dirty,
   input  logic [8*LINE_BYTES-1:0]                    ev_data,
   output logic                                       mw_valid,
   input  logic                                       mw_ack,
   output logic [ADDR_W-$clog2(LINE_BYTES/2)-1:0]     mw_addr,
   output logic [4*LINE_BYTES-1:0]                    mw_data,
   output logic [LINE_BYTES/2-1:0]                    mw_mask
);
   localparam int HALF_BYTES = LINE_BYTES / 2;
   localparam int HALF_BITS  = 8 * HALF_BYTES;
   localparam int LANES      = HALF_BYTES / WORD_BYTES;
   localparam int LANE_W     = $clog2(LANES);
   localparam int OFF_W      = $clog2(HALF_BYTES);
   localparam int HA_W       = ADDR_W - OFF_W;
   localparam int WA_W       = ADDR_W - $clog2(WORD_BYTES);
   localparam int PTR_W      = $clog2(DEPTH);
   localparam int CNT_W      = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("wbuf_coalesce: DEPTH must be a power of two, at least 2");
      end
      if ((WORD_BYTES & (WORD_BYTES - 1)) != 0 || LANES < 2 ||
          (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_geom
         $error("wbuf_coalesce: line and word sizes must be powers of two, half line >= 2 words");
      end
   endgenerate

   // Entry storage
   logic [DEPTH-1:0]      e_valid;
   logic [DEPTH-1:0]      e_coal;
   logic [HA_W-1:0]       e_tag  [DEPTH];
   logic [HALF_BYTES-1:0] e_mask [DEPTH];
   logic [HALF_BITS-1:0]  e_data [DEPTH];

   logic [PTR_W-1:0] head, tail, tail_nx1, ev_hi_slot;
   logic [CNT_W-1:0] count, free_cnt;

   // Store placed into its half line
   logic [LANE_W-1:0]     st_lane;
   logic [HA_W-1:0]       st_tag;
   logic [HALF_BYTES-1:0] st_bmask;
   logic [HALF_BITS-1:0]  st_hdata;

   logic [DEPTH-1:0] merge_cand;
   logic             hit;
   logic [PTR_W-1:0] hit_idx;
   logic             head_lock, pop, st_merge;
   logic [1:0]       push_n;
   wb_req_e          req_kind;

   assign st_lane  = st_addr[LANE_W-1:0];
   assign st_tag   = st_addr[WA_W-1:LANE_W];
   assign st_bmask = {{(HALF_BYTES-WORD_BYTES){1'b0}}, st_strb} << (int'(st_lane) * WORD_BYTES);
   assign st_hdata = {{(HALF_BITS-8*WORD_BYTES){1'b0}}, st_data} << (int'(st_lane) * 8 * WORD_BYTES);

   assign free_cnt   = CNT_W'(DEPTH) - count;
   assign tail_nx1   = tail + 1'b1;
   assign ev_hi_slot = ev_dirty[0] ? tail_nx1 : tail;

   // Only coalescable entries not yet offered to memory may absorb a store.
   always_comb begin
      merge_cand = e_valid & e_coal;
      if (head_lock) merge_cand[head] = 1'b0;
   end

   wbuf_match #(
      .DEPTH (DEPTH),
      .TAG_W (HA_W),
      .ENABLE(COALESCE_EN)
   ) u_match (
      .cand   (merge_cand),
      .tags   (e_tag),
      .probe  (st_tag),
      .hit    (hit),
      .hit_idx(hit_idx)
   );

   wbuf_alloc #(
      .CNT_W(CNT_W)
   ) u_alloc (
      .st_valid(st_valid),
      .st_coal (st_coal),
      .hit     (hit),
      .ev_valid(ev_valid),
      .ev_dirty(ev_dirty),
      .free_cnt(free_cnt),
      .st_ready(st_ready),
      .ev_ready(ev_ready),
      .st_merge(st_merge),
      .push_n  (push_n),
      .req_kind(req_kind)
   );

   wbuf_drain u_drain (
      .clk        (clk),
      .rst_n      (rst_n),
      .head_valid (e_valid[head]),
      .multi      (count > CNT_W'(1)),
      .req_present(st_valid || ev_valid),
      .mw_ack     (mw_ack),
      .mw_valid   (mw_valid),
      .head_lock  (head_lock),
      .pop        (pop)
   );

   // Control state: occupancy, pointers, flags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_valid <= '0;
         e_coal  <= '0;
         head    <= '0;
         tail    <= '0;
         count   <= '0;
      end else begin
         if (pop) begin
            e_valid[head] <= 1'b0;
            head          <= head + 1'b1;
         end
         unique case (req_kind)
            WB_REQ_STORE: begin
               if (!st_merge) begin
                  e_valid[tail] <= 1'b1;
                  e_coal[tail]  <= st_coal;
               end
            end
            WB_REQ_EVICT: begin
               if (ev_dirty[0]) begin
                  e_valid[tail] <= 1'b1;
                  e_coal[tail]  <= 1'b0;
               end
               if (ev_dirty[1]) begin
                  e_valid[ev_hi_slot] <= 1'b1;
                  e_coal[ev_hi_slot]  <= 1'b0;
               end
            end
            default: ;
         endcase
         tail  <= tail + PTR_W'(push_n);
         count <= count + CNT_W'(push_n) - CNT_W'(pop);
      end
   end

   // Payload: tag, mask, data (no reset needed; guarded by e_valid)
   always_ff @(posedge clk) begin
      unique case (req_kind)
         WB_REQ_STORE: begin
            if (st_merge) begin
               for (int b = 0; b < HALF_BYTES; b++) begin
                  if (st_bmask[b]) e_data[hit_idx][8*b +: 8] <= st_hdata[8*b +: 8];
               end
               e_mask[hit_idx] <= e_mask[hit_idx] | st_bmask;
            end else begin
               e_tag[tail]  <= st_tag;
               e_mask[tail] <= st_bmask;
               e_data[tail] <= st_hdata;
            end
         end
         WB_REQ_EVICT: begin
            if (ev_dirty[0]) begin
               e_tag[tail]  <= {ev_line, 1'b0};
               e_mask[tail] <= '1;
               e_data[tail] <= ev_data[HALF_BITS-1:0];
            end
            if (ev_dirty[1]) begin
               e_tag[ev_hi_slot]  <= {ev_line, 1'b1};
               e_mask[ev_hi_slot] <= '1;
               e_data[ev_hi_slot] <= ev_data[2*HALF_BITS-1:HALF_BITS];
            end
         end
         default: ;
      endcase
   end

   assign mw_addr = e_tag[head];
   assign mw_data = e_data[head];
   assign mw_mask = e_mask[head];

endmodule

// File: rtl/wbuf_chk.sv
module wbuf_chk #(
   parameter int DEPTH      = 8,
   parameter int HA_W       = 28,
   parameter int HALF_BYTES = 16,
   parameter int CNT_W      = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    st_valid,
   input logic                    st_ready,
   input logic                    st_coal,
   input logic                    ev_valid,
   input logic                    ev_ready,
   input logic [1:0]              ev_dirty,
   input logic                    mw_valid,
   input logic                    mw_ack,
   input logic [HA_W-1:0]         mw_addr,
   input logic [HALF_BYTES-1:0]   mw_mask,
   input logic [8*HALF_BYTES-1:0] mw_data,
   input logic [CNT_W-1:0]        count
);
   assert_drain_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mw_valid && !mw_ack |=> mw_valid && $stable(mw_addr) && $stable(mw_mask) && $stable(mw_data));

   assert_evict_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid |-> !st_ready);

   assert_full_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_W'(DEPTH)) && st_valid && !st_coal |-> !st_ready);

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   assert_pair_atomic_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid && ev_ready && (ev_dirty == 2'b11)
      |=> count == $past(count) + CNT_W'(2) - CNT_W'($past(mw_valid && mw_ack)));

   assert_clean_evict_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid && (ev_dirty == 2'b00) |-> ev_ready);

   assert_lone_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_W'(1)) && (st_valid || ev_valid) && !$past(mw_valid) |-> !mw_valid);
endmodule

bind wbuf_coalesce wbuf_chk #(
   .DEPTH     (DEPTH),
   .HA_W      (HA_W),
   .HALF_BYTES(HALF_BYTES),
   .CNT_W     (CNT_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .st_valid(st_valid),
   .st_ready(st_ready),
   .st_coal (st_coal),
   .ev_valid(ev_valid),
   .ev_ready(ev_ready),
   .ev_dirty(ev_dirty),
   .mw_valid(mw_valid),
   .mw_ack  (mw_ack),
   .mw_addr (mw_addr),
   .mw_mask (mw_mask),
   .mw_data (mw_data),
   .count   (count)
);

// File: tb/wbuf_coalesce_tb_top.sv
`timescale 1ns/1ps
module wbuf_coalesce_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         st_valid = 1'b0, st_coal = 1'b0;
   logic         st_ready;
   logic [29:0]  st_addr = '0;
   logic [3:0]   st_strb = '0;
   logic [31:0]  st_data = '0;
   logic         ev_valid = 1'b0;
   logic         ev_ready;
   logic [26:0]  ev_line = '0;
   logic [1:0]   ev_dirty = '0;
   logic [255:0] ev_data = '0;
   logic         mw_valid;
   logic         mw_ack = 1'b0;
   logic [27:0]  mw_addr;
   logic [127:0] mw_data;
   logic [15:0]  mw_mask;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #4 clk = ~clk;   // 125 MHz

   wbuf_coalesce dut_i (
      .clk(clk), .rst_n(rst_n),
      .st_valid(st_valid), .st_ready(st_ready), .st_coal(st_coal),
      .st_addr(st_addr), .st_strb(st_strb), .st_data(st_data),
      .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_line(ev_line),
      .ev_dirty(ev_dirty), .ev_data(ev_data),
      .mw_valid(mw_valid), .mw_ack(mw_ack), .mw_addr(mw_addr),
      .mw_data(mw_data), .mw_mask(mw_mask)
   );

   // Stimulus table: {coal, byte address, strobes, data}
   localparam logic [68:0] STIM [10] = '{
      {1'b1, 32'h100, 4'hF, 32'h11111111},
      {1'b1, 32'h104, 4'hF, 32'h22222222},
      {1'b1, 32'h108, 4'hF, 32'h33333333},
      {1'b1, 32'h10C, 4'hF, 32'h44444444},
      {1'b1, 32'h110, 4'hF, 32'h55555555},
      {1'b1, 32'h114, 4'hF, 32'h66666666},
      {1'b1, 32'h100, 4'h1, 32'h000000AA},
      {1'b0, 32'h118, 4'hF, 32'h77777777},
      {1'b1, 32'h118, 4'h3, 32'h0000BBBB},
      {1'b1, 32'h11C, 4'hC, 32'hCCCC0000}
   };
   // Expected writes in drain order: {half address, mask, data}
   localparam logic [171:0] EXPW [4] = '{
      {28'h10, 16'hFFFF, 128'h44444444_33333333_22222222_11111111},
      {28'h11, 16'hC3FF, 128'hCCCC0000_0000BBBB_66666666_55555555},
      {28'h10, 16'h0001, 128'h000000AA},
      {28'h11, 16'h0F00, 128'h00000000_77777777_00000000_00000000}
   };
   localparam string EXPTAG [4] = '{"R3", "R3", "R4", "R2"};

   function automatic logic [127:0] expand(input logic [15:0] m);
      logic [127:0] r;
      for (int b = 0; b < 16; b++) r[8*b +: 8] = {8{m[b]}};
      return r;
   endfunction

   task automatic compare(input string req, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Tasks start and end one nanosecond after a falling edge.
   task automatic do_store(input logic coal, input logic [31:0] baddr,
                           input logic [3:0] strb, input logic [31:0] data);
      st_valid = 1'b1; st_coal = coal; st_addr = baddr[31:2];
      st_strb = strb; st_data = data;
      #1;
      while (!st_ready) begin @(negedge clk); #2; end
      @(negedge clk); #1;
   endtask

   task automatic drain_one(input string req, input logic [27:0] ea,
                            input logic [15:0] em, input logic [127:0] ed);
      for (int n = 0; n < 50 && !mw_valid; n++) begin @(negedge clk); #1; end
      compare(req, 256'(mw_addr), 256'(ea));
      compare(req, 256'(mw_mask), 256'(em));
      compare(req, 256'(mw_data & expand(em)), 256'(ed & expand(em)));
      mw_ack = 1'b1;
      @(negedge clk); #1;
      mw_ack = 1'b0;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [27:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      compare("R1", 256'(mw_valid), 256'(0));
      compare("R1", 256'(st_ready), 256'(1));
      compare("R1", 256'(ev_ready), 256'(1));

      // Table walk: merges, head locking, non-coalescing entries
      for (int i = 0; i < 10; i++) begin
         do_store(STIM[i][68], STIM[i][67:36], STIM[i][35:32], STIM[i][31:0]);
      end
      st_valid = 1'b0;
      for (int i = 0; i < 4; i++) begin
         drain_one(EXPTAG[i], EXPW[i][171:144], EXPW[i][143:128], EXPW[i][127:0]);
      end
      compare("R9", 256'(mw_valid), 256'(0));

      // R10: lone entry waits while a request is presented
      do_store(1'b1, 32'h200, 4'hF, 32'hA0A0A0A0);
      st_addr = 30'(32'h204 >> 2); st_data = 32'hB1B1B1B1;
      #1;
      compare("R10", 256'(mw_valid), 256'(0));
      @(negedge clk); #1;
      st_valid = 1'b0;
      #1;
      compare("R10", 256'(mw_valid), 256'(1));
      drain_one("R3", 28'h20, 16'h00FF, 128'hB1B1B1B1_A0A0A0A0);

      // R2 / R8: eight non-coalescing stores fill the buffer
      for (int i = 0; i < 8; i++) do_store(1'b0, 32'h300 + 32'(4*i), 4'hF, 32'h30303030 + 32'(i));
      st_valid = 1'b1; st_coal = 1'b0; st_addr = 30'(32'h320 >> 2);
      #1;
      compare("R8", 256'(st_ready), 256'(0));
      st_coal = 1'b1; st_addr = 30'(32'h300 >> 2);
      #1;
      compare("R2", 256'(st_ready), 256'(0));
      st_valid = 1'b0;
      for (int i = 0; i < 8; i++) begin
         drain_one("R2", 28'h30 + 28'(i / 4), 16'hF << (4 * (i % 4)),
                   128'(32'h30303030 + 32'(i)) << (32 * (i % 4)));
      end

      // R7 / R5: two-half eviction needs two free entries
      for (int i = 0; i < 7; i++) do_store(1'b0, 32'h400 + 32'(4*i), 4'hF, 32'h40404040 + 32'(i));
      st_valid = 1'b0;
      ev_valid = 1'b1; ev_line = 27'h50; ev_dirty = 2'b11;
      ev_data = {128'hDEADBEEF_CAFEF00D_13579BDF_2468ACE0, 128'h01234567_89ABCDEF_FEDCBA98_76543210};
      #1;
      compare("R7", 256'(ev_ready), 256'(0));
      compare("R8", 256'(st_ready), 256'(0));
      held = mw_addr;
      @(negedge clk); #1;
      compare("R9", 256'(mw_addr), 256'(held));
      drain_one("R9", 28'h40, 16'h000F, 128'h40404040);
      compare("R7", 256'(ev_ready), 256'(1));
      @(negedge clk); #1;
      ev_valid = 1'b0;
      for (int i = 1; i < 7; i++) begin
         drain_one("R9", 28'h40 + 28'(i / 4), 16'hF << (4 * (i % 4)),
                   128'(32'h40404040 + 32'(i)) << (32 * (i % 4)));
      end
      drain_one("R5", 28'hA0, 16'hFFFF, 128'h01234567_89ABCDEF_FEDCBA98_76543210);
      drain_one("R5", 28'hA1, 16'hFFFF, 128'hDEADBEEF_CAFEF00D_13579BDF_2468ACE0);

      // R6: clean eviction takes no entry
      ev_valid = 1'b1; ev_line = 27'h60; ev_dirty = 2'b00;
      #1;
      compare("R6", 256'(ev_ready), 256'(1));
      @(negedge clk); #1;
      ev_valid = 1'b0;
      repeat (2) @(negedge clk);
      #1;
      compare("R6", 256'(mw_valid), 256'(0));

      // R5: only the upper half dirty
      ev_valid = 1'b1; ev_dirty = 2'b10;
      @(negedge clk); #1;
      ev_valid = 1'b0;
      drain_one("R5", 28'hC1, 16'hFFFF, 128'hDEADBEEF_CAFEF00D_13579BDF_2468ACE0);
      compare("R5", 256'(mw_valid), 256'(0));

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule